// File: doc/BRIEF.md
# CAM Bus Cycle Sequencer

This block is a synchronous master that runs one bus cycle at a time against an external content-addressable memory. The memory shares a 16-bit data path with the sequencer in both directions. The surrounding logic presents a request made of an operation code and write data. The sequencer then walks through three phases: setup, strobe-low and recovery. During them it drives an active-low cycle strobe, a direction select, a command/data qualifier and a compare-enable. When the cycle ends it returns read data with a one-clock done pulse.

For a compare cycle, the memory's active-low match line is passed through a synchronizer. It is then held in a match-result flag that later control flow can branch on. The data path is modelled as separate in, out and output-enable vectors. The pad-level tri-state buffer sits outside the block.

Top module: `cam_cycle_seq`

## Requirements
- R1: While reset is high and after it is released, the outputs hold these values: strobe `bus_en_n`=1, direction `bus_wr_n`=1, qualifier `bus_cmd_n`=1, compare-enable `bus_cmp_n`=1, `bus_dq_oe`=0, `busy`=0, `done`=0 and `match_hit`=0.
- R2: The operation code sets the line levels seen at the strobe's falling edge (1 = high):

  | `req_op` | Operation | `bus_wr_n` | `bus_cmd_n` | `bus_cmp_n` |
  |---|---|---|---|---|
  | 0 | command write | 0 | 0 | 1 |
  | 1 | data write | 0 | 1 | 1 |
  | 2 | data read | 1 | 1 | 1 |
  | 3 | compare write | 0 | 1 | 0 |
- R3: The strobe falls SETUP_CLKS clocks after the request is accepted and stays low for STROBE_CLKS clocks. While it is low, the direction, qualifier, compare-enable and outgoing data do not change.
- R4: For write operations, `bus_dq_out` carries `req_wdata` with `bus_dq_oe`=1 while the strobe is low. `bus_dq_oe` is 0 throughout a read cycle and from the strobe's rising edge onward.
- R5: For a read, `rd_data` equals the value on `bus_dq_in` at the clock edge where the strobe returns high, and it is valid when `done` is high.
- R6: `busy` is high from the edge that accepts a request until the edge that raises `done`. That span is SETUP_CLKS+STROBE_CLKS+RECOV_CLKS clocks, plus SYNC_STAGES more clocks for compare writes. `done` is high for exactly one clock.
- R7: While `busy` is high, `req_valid` is ignored and starts no further cycle.
- R8: At the end of a compare write, `match_hit` takes the inverse of the synchronized `match_n`, sampled after the strobe's rising edge. It is cleared on the edge that accepts the next compare write.
- R9: A cycle that is not a compare write leaves `match_hit` unchanged, whatever level `match_n` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; accepted only when idle |
| req_op | input | 2 | Operation code (see R2) |
| req_wdata | input | 16 | Data to drive for write operations |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 16 | Data captured by the last read |
| match_hit | output | 1 | Latched result of the last compare write |
| bus_en_n | output | 1 | Active-low cycle strobe |
| bus_wr_n | output | 1 | Direction: 0 write, 1 read |
| bus_cmd_n | output | 1 | 0 command cycle, 1 data cycle |
| bus_cmp_n | output | 1 | Active-low compare-enable |
| bus_dq_out | output | 16 | Outgoing bus data |
| bus_dq_oe | output | 1 | Bus drive enable |
| bus_dq_in | input | 16 | Incoming bus data |
| match_n | input | 1 | Active-low match flag from the memory |

## Verification
All four operation codes are run against six data words: all zeros, all ones, two alternating patterns and the single-bit extremes. A dropped or swapped data bit therefore shows up in write capture or read return. Each combination is repeated with the memory model asserting and not asserting its match line. This separates compare writes, which must latch the flag, from the other cycles, which must ignore the flag even when the line is held low. The model raises the match line only after the strobe rises, so a flag latched too early is caught. A request pulsed in the middle of a cycle checks that no extra strobe follows.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD_WR = 2'd0,
        OP_DAT_WR = 2'd1,
        OP_DAT_RD = 2'd2,
        OP_CMP_WR = 2'd3
    } cam_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_RECOV  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cseq_phase_timer.sv
module cseq_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/cam_cycle_seq.sv
module cam_cycle_seq
    import cam_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SETUP_CLKS  = 1,
    parameter int STROBE_CLKS = 1,
    parameter int RECOV_CLKS  = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              match_hit,
    output logic              bus_en_n,
    output logic              bus_wr_n,
    output logic              bus_cmd_n,
    output logic              bus_cmp_n,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    input  logic              match_n
);
    localparam int MAXLEN    = SETUP_CLKS + STROBE_CLKS + RECOV_CLKS + SYNC_STAGES;
    localparam int CW        = $clog2(MAXLEN + 1);
    localparam int RLEN_PLN  = RECOV_CLKS - 1;
    localparam int RLEN_CMP  = RECOV_CLKS + SYNC_STAGES - 1;

    typedef struct packed {
        seq_st_e           st;
        logic              en_n;
        logic              wr_n;
        logic              cmd_n;
        logic              cmp_n;
        logic              oe;
        logic              is_cmp;
        logic              done;
        logic              hit;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          match_sync_n;
    cam_op_e       op;

    cseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_match_sync (
        .clk (clk),
        .rst (rst),
        .d   (match_n),
        .q   (match_sync_n)
    );

    cseq_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign op = cam_op_e'(req_op);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_SETUP;
                    r_d.wr_n   = (op == OP_DAT_RD);
                    r_d.cmd_n  = (op != OP_CMD_WR);
                    r_d.cmp_n  = (op != OP_CMP_WR);
                    r_d.is_cmp = (op == OP_CMP_WR);
                    r_d.oe     = (op != OP_DAT_RD);
                    r_d.dout   = req_wdata;
                    if (op == OP_CMP_WR) r_d.hit = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CW'(SETUP_CLKS - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    r_d.st   = ST_STROBE;
                    r_d.en_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(STROBE_CLKS - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    r_d.st   = ST_RECOV;
                    r_d.en_n = 1'b1;
                    r_d.oe   = 1'b0;
                    if (r_q.wr_n) r_d.rdata = bus_dq_in;
                    tmr_load = 1'b1;
                    tmr_val  = r_q.is_cmp ? CW'(RLEN_CMP) : CW'(RLEN_PLN);
                end
            end
            ST_RECOV: begin
                if (tmr_last) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    if (r_q.is_cmp) r_d.hit = ~match_sync_n;
                    r_d.wr_n   = 1'b1;
                    r_d.cmd_n  = 1'b1;
                    r_d.cmp_n  = 1'b1;
                    r_d.is_cmp = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, en_n: 1'b1, wr_n: 1'b1, cmd_n: 1'b1, cmp_n: 1'b1,
                     oe: 1'b0, is_cmp: 1'b0, done: 1'b0, hit: 1'b0,
                     dout: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign rd_data    = r_q.rdata;
    assign match_hit  = r_q.hit;
    assign bus_en_n   = r_q.en_n;
    assign bus_wr_n   = r_q.wr_n;
    assign bus_cmd_n  = r_q.cmd_n;
    assign bus_cmp_n  = r_q.cmp_n;
    assign bus_dq_out = r_q.dout;
    assign bus_dq_oe  = r_q.oe;

    // R3
    strobe_ctrl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_en_n && !$past(bus_en_n)) |->
            ($stable(bus_wr_n) && $stable(bus_cmd_n) && $stable(bus_cmp_n) && $stable(bus_dq_out)));

    // R4
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr_n |-> !bus_dq_oe);

    // R4
    release_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_n) |-> !bus_dq_oe);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R8
    hit_set_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        (match_hit && !$past(match_hit)) |-> done);

    // R8
    hit_clear_on_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(match_hit) |-> (busy && !bus_cmp_n));
endmodule

// File: tb/cam_cycle_seq_bench.sv
`timescale 1ns/1ps
module cam_cycle_seq_bench;
    localparam int S = 1, T = 1, R = 1, SY = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        busy, done, match_hit;
    logic [15:0] rd_data, bus_dq_out;
    logic        bus_en_n, bus_wr_n, bus_cmd_n, bus_cmp_n, bus_dq_oe;
    logic [15:0] bus_dq_in;
    logic        match_n;

    int checks = 0;
    int errors = 0;

    // memory model state
    logic [15:0] rd_val = 16'h0;
    bit          slave_want = 1'b0;
    logic        prev_en = 1'b1;
    logic        sl_wr_n, sl_cmd_n, sl_cmp_n, sl_oe;
    logic [15:0] sl_data;
    int          sl_falls = 0;

    always #2.5 clk = ~clk;

    cam_cycle_seq #(.DATA_W(16), .SETUP_CLKS(S), .STROBE_CLKS(T),
                    .RECOV_CLKS(R), .SYNC_STAGES(SY)) u_cam_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .match_hit(match_hit), .bus_en_n(bus_en_n), .bus_wr_n(bus_wr_n),
        .bus_cmd_n(bus_cmd_n), .bus_cmp_n(bus_cmp_n), .bus_dq_out(bus_dq_out),
        .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in), .match_n(match_n)
    );

    // Memory model: captures at strobe fall, asserts match line only after strobe rise.
    // It raises the line for any cycle when asked, so R9 sees a noisy line.
    always @(negedge clk) begin
        if (rst) begin
            bus_dq_in = 16'h0;
            match_n   = 1'b1;
            prev_en   = 1'b1;
            sl_wr_n = 1'b1; sl_cmd_n = 1'b1; sl_cmp_n = 1'b1; sl_oe = 1'b0; sl_data = 16'h0;
        end else begin
            if (prev_en && !bus_en_n) begin
                sl_wr_n  = bus_wr_n;
                sl_cmd_n = bus_cmd_n;
                sl_cmp_n = bus_cmp_n;
                sl_oe    = bus_dq_oe;
                sl_data  = bus_dq_out;
                sl_falls = sl_falls + 1;
                bus_dq_in = rd_val;
            end
            if (!prev_en && bus_en_n && busy) match_n = ~slave_want;
            if (!busy) match_n = 1'b1;
            prev_en = bus_en_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    bit exp_hit = 1'b0;

    task automatic run_op(input logic [1:0] op, input logic [15:0] wd,
                          input logic [15:0] rv, input bit want);
        int busy_cnt, setup_cnt, low_cnt, guard;
        bit seen_low, oe_bad;
        rd_val = rv;
        slave_want = want;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 busy after accept", busy, 1);
        if (op == 2'd3) chk("R8 clear at compare start", match_hit, 0);
        busy_cnt = 0; setup_cnt = 0; low_cnt = 0; guard = 0;
        seen_low = 1'b0; oe_bad = 1'b0;
        while (!done && guard < 64) begin
            if (busy) busy_cnt++;
            if (busy && bus_en_n && !seen_low) setup_cnt++;
            if (!bus_en_n) begin low_cnt++; seen_low = 1'b1; end
            if (seen_low && bus_en_n && bus_dq_oe) oe_bad = 1'b1;
            if (op == 2'd2 && bus_dq_oe) oe_bad = 1'b1;
            guard++;
            @(negedge clk);
        end
        chk("R6 done seen", done, 1);
        chk("R6 busy low at done", busy, 0);
        chk("R6 busy length", busy_cnt, S + T + R + ((op == 2'd3) ? SY : 0));
        chk("R3 setup length", setup_cnt, S);
        chk("R3 strobe length", low_cnt, T);
        chk("R2 direction", sl_wr_n, (op == 2'd2));
        chk("R2 qualifier", sl_cmd_n, (op != 2'd0));
        chk("R2 compare enable", sl_cmp_n, (op != 2'd3));
        chk("R4 release", oe_bad, 0);
        if (op != 2'd2) begin
            chk("R4 write data", sl_data, wd);
            chk("R4 drive enable", sl_oe, 1);
        end else begin
            chk("R5 read data", rd_data, rv);
        end
        if (op == 2'd3) begin
            exp_hit = want;
            chk("R8 match latched", match_hit, want);
        end else begin
            chk("R9 match unchanged", match_hit, exp_hit);
        end
        @(negedge clk);
        chk("R6 done one clock", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pats [6];
        int falls0;
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
        pats[3] = 16'h5A5A; pats[4] = 16'h0001; pats[5] = 16'h8000;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 strobe", bus_en_n, 1);
        chk("R1 busy", busy, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 after release
        chk("R1 strobe", bus_en_n, 1);
        chk("R1 direction", bus_wr_n, 1);
        chk("R1 qualifier", bus_cmd_n, 1);
        chk("R1 compare enable", bus_cmp_n, 1);
        chk("R1 drive enable", bus_dq_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 match", match_hit, 0);

        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 6; p++)
                for (int o = 0; o < 4; o++)
                    run_op(o[1:0], pats[p], ~pats[p] ^ 16'h0F0F, w[0]);

        // R8 clear then set again across back-to-back compares
        run_op(2'd3, 16'h1234, 16'h0, 1'b1);
        run_op(2'd3, 16'h4321, 16'h0, 1'b0);
        run_op(2'd1, 16'h7777, 16'h0, 1'b1);

        // R7: request pulsed mid-cycle is ignored
        falls0 = sl_falls;
        rd_val = 16'hBEEF;
        slave_want = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_wdata = 16'h0;
        @(negedge clk);
        req_op = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 64 && !done; g++) @(negedge clk);
        chk("R5 read data", rd_data, 16'hBEEF);
        repeat (4) begin
            @(negedge clk);
            chk("R7 stays idle", busy, 0);
        end
        chk("R7 single strobe", sl_falls - falls0, 1);
        chk("R7 match untouched", match_hit, exp_hit);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule